// File: doc/BRIEF.md
# Page-Mode DRAM Pin Responder with Extended Data Out

This block behaves like a multiplexed-address dynamic RAM as seen from its pins, backed by a small synchronous word array. The controller drives a 9-bit shared address bus, an active-low row strobe, two active-low column strobes (one per byte lane), an active-low write enable and an active-low output enable. A fast system clock samples all of these pins, and the block detects strobe edges by comparing each pin with its value on the previous clock edge.

The row half of the address is taken when the row strobe falls. The column half is taken when the merged column strobe falls. The merged strobe is active while either lane strobe is low. From these events the block decodes reads, byte-lane writes and refresh-only cycles. A refresh-only cycle is selected when the column strobe is already low as the row strobe falls. Read data stays on the bus after the column strobe rises and is dropped only at the next column strobe fall. This lets a controller run short page-mode column cycles.

The data bus is split into an input, an output and a per-lane output enable. An external pad ring merges these into the bidirectional pins.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, both lane output enables are 0.
- R2: The word addressed is {row, column}, where the row is sampled at the row strobe fall and the column at the merged column strobe fall. Only the low AW bits of this 18-bit value select the array word, so higher bits are ignored. Read data and its lane enables appear on the second clock edge after the column strobe fall is sampled.
- R3: The lower strobe (lcas_n) controls data bits 7:0 and dq_oe[0]. The upper strobe (ucas_n) controls data bits 15:8 and dq_oe[1]. A lane whose strobe stays high is neither written nor driven.
- R4: The column is latched at the first lane strobe fall. A second lane falling later in the same column cycle does not re-latch the column.
- R5: Output is driven only while oe_n is low and we_n is high. A read begins when the later of the column strobe and the output enable has fallen.
- R6: A write takes effect at the later of the column strobe fall and the write enable fall. The data stored is the dq_i value sampled at the earlier of the two falls.
- R7: After the column strobe rises, read data and its enables are held. They are cleared at the clock edge that samples the next column strobe fall, and the new column's data follows.
- R8: When the column strobe is low as the row strobe falls, the cycle is refresh-only. The outputs stay disabled, the external address is ignored, and write enable activity changes no stored word.
- R9: Each refresh-only cycle advances an internal 9-bit row counter by one, wrapping from 511 to 0.
- R10: Once the row strobe and both column strobes are all high, the cycle ends and the outputs are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Shared row/column address |
| dq_i | input | 16 | Data from the bus |
| dq_o | output | 16 | Data to the bus |
| dq_oe | output | 2 | Per-lane output enables, bit 0 lower byte |

## Verification
The bench builds the block with AW set to 10, which gives a 1024-word array. With this size the bench can prefill every word and keep a full reference copy. The ten address bits are the nine column bits plus the lowest row bit. This means rows that differ only above bit 0 land on the same word, so the aliasing of ignored high address bits is directly observable. The refresh counter keeps its full 9-bit width regardless of AW, so a run of 520 refresh-only cycles crosses the 511-to-0 wrap.

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
  parameter int AW = 11,
  parameter int RW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          lcas_n,
  input  logic          ucas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [RW-1:0] addr,
  input  logic [15:0]   dq_i,
  output logic [15:0]   dq_o,
  output logic [1:0]    dq_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int FW    = 2 * RW;

  logic [15:0] mem [DEPTH];
  logic ras_q, cas_q, we_q;
  logic in_cycle, refresh, has_col;
  logic [RW-1:0] row, col, rcnt;
  logic [15:0] wdat;
  logic [1:0]  lane_en;

  wire cas_n    = lcas_n & ucas_n;
  wire ras_fall = ras_q & ~ras_n;
  wire cas_fall = cas_q & ~cas_n;
  wire we_fall  = we_q & ~we_n;
  wire end_c    = ras_n & cas_n;
  wire access   = in_cycle & ~refresh;
  wire [1:0] lane_cas_n = {ucas_n, lcas_n};

  function automatic logic [AW-1:0] word_idx(input logic [RW-1:0] r, input logic [RW-1:0] c);
    logic [FW-1:0] full;
    full = {r, c};
    return full[AW-1:0];
  endfunction

  wire wr_cas = access & cas_fall & ~we_n;
  wire wr_we  = access & we_fall & ~cas_n & ~cas_fall & has_col;
  wire wr_en  = wr_cas | wr_we;
  wire [AW-1:0] wr_idx  = wr_cas ? word_idx(row, addr) : word_idx(row, col);
  wire [15:0]   wr_data = (wr_cas & we_fall) ? dq_i : wdat;
  wire [15:0]   rd_data = mem[word_idx(row, col)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      we_q     <= 1'b1;
      in_cycle <= 1'b0;
      refresh  <= 1'b0;
      has_col  <= 1'b0;
      row      <= '0;
      col      <= '0;
      rcnt     <= '0;
      wdat     <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
      if (ras_fall) begin
        in_cycle <= 1'b1;
        has_col  <= 1'b0;
        if (!cas_n) begin
          refresh <= 1'b1;
          row     <= rcnt;
          rcnt    <= RW'(rcnt + 1'b1);
        end else begin
          refresh <= 1'b0;
          row     <= addr;
        end
      end else if (end_c) begin
        in_cycle <= 1'b0;
        refresh  <= 1'b0;
        has_col  <= 1'b0;
      end else if (access && cas_fall) begin
        col     <= addr;
        has_col <= 1'b1;
      end
      if (we_fall && cas_n)
        wdat <= dq_i;
      else if (cas_fall && we_n)
        wdat <= dq_i;
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && !lane_cas_n[l])
        mem[wr_idx][l*8 +: 8] <= wr_data[l*8 +: 8];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        lane_en[l] <= 1'b0;
      else if (!access || end_c || ras_fall || cas_fall || oe_n || !we_n)
        lane_en[l] <= 1'b0;
      else if (!lane_cas_n[l] && has_col)
        lane_en[l] <= 1'b1;
    end

    assign dq_o[l*8 +: 8] = lane_en[l] ? rd_data[l*8 +: 8] : 8'h00;
  end

  assign dq_oe = lane_en;
endmodule

module edo_dram_model_chk #(
  parameter int RW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          lcas_n,
  input logic          ucas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [1:0]    dq_oe,
  input logic          refresh,
  input logic [RW-1:0] rcnt
);
  p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> $past(!oe_n && we_n));

  p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> (dq_oe == 2'b00));

  p_refresh_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> (dq_oe == 2'b00));

  p_refresh_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh) |-> (rcnt == RW'($past(rcnt) + 1'b1)));

  p_cycle_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n && lcas_n && ucas_n) |-> (dq_oe == 2'b00));
endmodule

bind edo_dram_model edo_dram_model_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
  .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe), .refresh(refresh), .rcnt(rcnt)
);

// File: tb/edo_dram_model_bench.sv
module edo_dram_model_bench;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe;
  logic [15:0] model [DEPTH];
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  edo_dram_model #(.AW(AW)) u_edo_dram_model (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  function automatic logic [AW-1:0] m_idx(input logic [8:0] r, input logic [8:0] c);
    logic [17:0] f;
    f = {r, c};
    return f[AW-1:0];
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] lanes);
    return {{8{lanes[1]}}, {8{lanes[0]}}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic close_cycle();
    lcas_n = 1'b1; ucas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    idle(2);
  endtask

  task automatic write_word(input logic [8:0] r, input logic [8:0] c, input logic [15:0] d,
                            input logic [1:0] lanes, input bit we_first);
    addr = r; ras_n = 1'b0; idle(2);
    if (we_first) begin
      dq_i = d; we_n = 1'b0; idle(2);
      dq_i = ~d; addr = c; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; idle(2);
    end else begin
      dq_i = d; addr = c; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; idle(2);
      dq_i = ~d; we_n = 1'b0; idle(2);
    end
    close_cycle();
    model[m_idx(r, c)] = (model[m_idx(r, c)] & ~lane_mask(lanes)) | (d & lane_mask(lanes));
  endtask

  task automatic read_word(input logic [8:0] r, input logic [8:0] c, input logic [1:0] lanes,
                           input string req);
    addr = r; oe_n = 1'b0; ras_n = 1'b0; idle(2);
    addr = c; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; idle(3);
    chk({req, " enables"}, 32'(dq_oe), 32'(lanes));
    chk({req, " data"}, 32'(dq_o), 32'(model[m_idx(r, c)] & lane_mask(lanes)));
    close_cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] ref_w;
    void'($urandom(32'd7261));
    idle(4);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset enables", 32'(dq_oe), 32'd0);

    for (int i = 0; i < DEPTH; i++)
      write_word(9'(i >> 9), 9'(i), 16'(i * 16'h9E37) ^ 16'h5A5A, 2'b11, i[0]);

    read_word(9'd0, 9'd3, 2'b11, "R2 prefill");
    write_word(9'd2, 9'd7, 16'h7777, 2'b11, 1'b0);
    read_word(9'd4, 9'd7, 2'b11, "R2 aliasing");

    write_word(9'd3, 9'd5, 16'hC0DE, 2'b11, 1'b1);
    read_word(9'd3, 9'd5, 2'b11, "R6 we-first");
    write_word(9'd3, 9'd6, 16'hBEEF, 2'b11, 1'b0);
    read_word(9'd3, 9'd6, 2'b11, "R6 cas-first");

    write_word(9'd1, 9'd9, 16'hAAAA, 2'b11, 1'b0);
    write_word(9'd1, 9'd9, 16'h1234, 2'b01, 1'b0);
    read_word(9'd1, 9'd9, 2'b01, "R3 lower lane");
    read_word(9'd1, 9'd9, 2'b11, "R3 upper kept");
    chk("R3 merged byte", 32'(model[m_idx(9'd1, 9'd9)]), 32'h0000AA34);

    addr = 9'd1; oe_n = 1'b0; ras_n = 1'b0; idle(2);
    addr = 9'd10; lcas_n = 1'b0; idle(2);
    addr = 9'd20; ucas_n = 1'b0; idle(3);
    chk("R4 both lanes", 32'(dq_oe), 32'd3);
    chk("R4 first column", 32'(dq_o), 32'(model[m_idx(9'd1, 9'd10)]));
    lcas_n = 1'b1; ucas_n = 1'b1; idle(3);
    chk("R7 hold enables", 32'(dq_oe), 32'd3);
    chk("R7 hold data", 32'(dq_o), 32'(model[m_idx(9'd1, 9'd10)]));
    lcas_n = 1'b0; ucas_n = 1'b0; idle(1);
    chk("R7 release on fall", 32'(dq_oe), 32'd0);
    idle(2);
    chk("R7 next column", 32'(dq_o), 32'(model[m_idx(9'd1, 9'd20)]));
    oe_n = 1'b1; idle(2);
    chk("R5 oe high", 32'(dq_oe), 32'd0);
    oe_n = 1'b0; idle(2);
    chk("R5 oe fall later", 32'(dq_oe), 32'd3);
    lcas_n = 1'b1; ucas_n = 1'b1; ras_n = 1'b1; idle(2);
    chk("R10 cycle end", 32'(dq_oe), 32'd0);
    close_cycle();

    lcas_n = 1'b0; ucas_n = 1'b0; idle(2);
    addr = 9'd6; oe_n = 1'b0; ras_n = 1'b0; idle(3);
    chk("R8 refresh hi-z", 32'(dq_oe), 32'd0);
    dq_i = 16'hDEAD; we_n = 1'b0; idle(2);
    we_n = 1'b1; idle(1);
    close_cycle();
    read_word(9'd6, 9'd6, 2'b11, "R8 no write");

    for (int k = 0; k < 520; k++) begin
      lcas_n = 1'b0; ucas_n = 1'b0; idle(1);
      ras_n = 1'b0; idle(2);
      ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; idle(1);
    end
    read_word(9'd3, 9'd5, 2'b11, "R9 after wrap");

    for (int k = 0; k < 400; k++) begin
      logic [8:0] r, c;
      logic [1:0] ln;
      r = 9'($urandom);
      c = 9'($urandom);
      ln = 2'($urandom_range(1, 3));
      if ($urandom_range(0, 1) == 0)
        write_word(r, c, 16'($urandom), ln, 1'($urandom));
      else
        read_word(r, c, ln, "R2 R3 random");
    end

    for (int i = 0; i < DEPTH; i += 97) begin
      ref_w = model[i];
      read_word(9'(i >> 9), 9'(i), 2'b11, "R6 sweep");
      chk("R6 model stable", 32'(model[i]), 32'(ref_w));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule